// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the controller's synchronized transmit level and the bus driver. It passes the level through: a low transmit level asks the driver to pull the bus dominant, and a high level lets the bus return recessive. A timer watches for transmit staying low too long, which happens with a stuck controller or with a disconnected input that defaults low. When the limit is hit, the driver is released and a timeout flag is raised.

Once timed out, the guard does not re-arm on the first rising edge of transmit. Transmit must stay high for a full recovery interval before a dominant command is accepted again. A path-enable from mode control forces the driver recessive and clears all timing state. An overtemperature input gates the driver command for as long as it is active. All durations are parameters counted in clock cycles (`TMO_CYC` for the dominant limit, `REC_CYC` for recovery).

Top module: `tx_dom_guard`

## Requirements
- R1: While `path_en` is 1, `overtemp` is 0 and no timeout is pending, `drv_dom` equals the inverse of `tx_lvl` in the same cycle (0 = dominant request, 1 = recessive).
- R2: After `TMO_CYC` consecutive clock edges with `tx_lvl` low and `path_en` high, `tmo_flag` is 1 and `drv_dom` is 0 from the next cycle on. The driver is dominant for exactly `TMO_CYC` cycles.
- R3: While the timeout is pending, `drv_dom` stays 0 whatever `tx_lvl` does. The flag clears in the cycle after the `REC_CYC`-th consecutive high sample of `tx_lvl`, and a later low level is then driven dominant at once.
- R4: A high period shorter than `REC_CYC` cycles does not clear the timeout. A low sample restarts the recovery count from zero.
- R5: A low period shorter than `TMO_CYC` followed by a high sample restarts the dominant count, so the next low period again gets the full `TMO_CYC` cycles.
- R6: While `path_en` is 0, `drv_dom` is 0. From the cycle after, `tmo_flag` is 0 and both counters are cleared.
- R7: While `overtemp` is 1, `drv_dom` is 0. The dominant timer keeps running on `tx_lvl`, and the driver follows `tx_lvl` again as soon as `overtemp` returns to 0.
- R8: After reset, `drv_dom` and `tmo_flag` are 0, and the counters do not wrap.
- R9: A transmit input held low from reset, as a floating input would be, ends in the timeout state with the bus recessive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_lvl | input | 1 | Synchronized transmit level, 0 requests dominant |
| path_en | input | 1 | Transmit path enable from mode control |
| overtemp | input | 1 | Overtemperature indication, 1 disables the driver |
| drv_dom | output | 1 | Driver command, 1 pulls the bus dominant |
| tmo_flag | output | 1 | Dominant timeout pending |

## Verification
Two events can fall in the same cycle: the dominant limit being reached, and a second cause of release (overtemperature or path disable). The bench holds transmit low with `overtemp` raised across the limit cycle, and separately drops `path_en` in the very cycle the limit is hit. The same is done for a recovery edge that coincides with a path disable. In each case a behavioural model decides, cycle by cycle, whether the flag sets and whether the driver stays released, and the design's outputs are compared against it on every clock.

// File: rtl/tx_dom_guard.sv
module tx_dom_guard #(
  parameter int TMO_CYC = 9000,
  parameter int REC_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_lvl,
  input  logic path_en,
  input  logic overtemp,
  output logic drv_dom,
  output logic tmo_flag
);
  localparam int CW = $clog2(TMO_CYC + 1);
  localparam int RW = $clog2(REC_CYC + 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYC - 1);
  localparam logic [RW-1:0] REC_LAST = RW'(REC_CYC - 1);

  logic [CW-1:0] dom_cnt;
  logic [RW-1:0] rec_cnt;
  logic          lock;
  logic          hit_tmo, hit_rec;

  assign hit_tmo = path_en & ~lock & ~tx_lvl & (dom_cnt == TMO_LAST);
  assign hit_rec = path_en & lock & tx_lvl & (rec_cnt == REC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_cnt <= '0;
      rec_cnt <= '0;
      lock    <= 1'b0;
    end else if (!path_en) begin
      dom_cnt <= '0;
      rec_cnt <= '0;
      lock    <= 1'b0;
    end else if (lock) begin
      dom_cnt <= '0;
      if (hit_rec) begin
        lock    <= 1'b0;
        rec_cnt <= '0;
      end else if (tx_lvl) begin
        rec_cnt <= rec_cnt + RW'(1);
      end else begin
        rec_cnt <= '0;
      end
    end else begin
      rec_cnt <= '0;
      if (hit_tmo) begin
        lock    <= 1'b1;
        dom_cnt <= '0;
      end else if (!tx_lvl) begin
        dom_cnt <= dom_cnt + CW'(1);
      end else begin
        dom_cnt <= '0;
      end
    end
  end

  assign drv_dom  = path_en & ~tx_lvl & ~lock & ~overtemp;
  assign tmo_flag = lock;

  // R2
  tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_tmo |=> (tmo_flag && !drv_dom));

  // R3
  rec_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo_flag) |-> ($past(tx_lvl) || !$past(path_en)));

  // R4
  rec_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && path_en && !tx_lvl) |=> tmo_flag);

  // R6
  path_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !path_en |=> !tmo_flag);

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_cnt < CW'(TMO_CYC)) && (rec_cnt < RW'(REC_CYC)));

  // R2
  tmo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> (!$past(tx_lvl) && $past(path_en)));
endmodule

// File: tb/tx_dom_guard_tb.sv
module tx_dom_guard_tb_top;
  localparam int TCLK = 10;
  localparam int TMO  = 20;
  localparam int REC  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_lvl = 1'b0, path_en = 1'b0, overtemp = 1'b0;
  logic drv_dom, tmo_flag;

  int total = 0, bad = 0;
  int m_dom = 0, m_rec = 0;
  bit m_lock = 0;
  bit fin = 0;

  tx_dom_guard #(.TMO_CYC(TMO), .REC_CYC(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_lvl(tx_lvl), .path_en(path_en),
    .overtemp(overtemp), .drv_dom(drv_dom), .tmo_flag(tmo_flag));

  always #(TCLK/2) clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit tx, bit en, bit ot, string tag);
    bit e_drv;
    @(negedge clk);
    tx_lvl = tx; path_en = en; overtemp = ot;
    #1;
    e_drv = en && !tx && !m_lock && !ot;
    chk(drv_dom == e_drv, {tag, " drv"}, drv_dom, e_drv);
    chk(tmo_flag == m_lock, {tag, " flag"}, tmo_flag, m_lock);
    @(posedge clk);
    if (!en) begin
      m_dom = 0; m_rec = 0; m_lock = 0;
    end else if (m_lock) begin
      if (tx) begin
        m_rec++;
        if (m_rec >= REC) begin m_lock = 0; m_rec = 0; m_dom = 0; end
      end else m_rec = 0;
    end else if (!tx) begin
      m_dom++;
      if (m_dom >= TMO) begin m_lock = 1; m_dom = 0; end
    end else m_dom = 0;
  endtask

  task automatic run(int n, bit tx, bit en, bit ot, string tag);
    for (int i = 0; i < n; i++) step(tx, en, ot, tag);
  endtask

  initial begin
    int wd = 0;
    while (!fin) begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    #1;
    chk(drv_dom == 1'b0, "R8 reset drv", drv_dom, 0);
    chk(tmo_flag == 1'b0, "R8 reset flag", tmo_flag, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9: floating low from reset ends in timeout
    run(TMO, 1'b0, 1'b1, 1'b0, "R9");
    step(1'b0, 1'b1, 1'b0, "R9");
    chk(tmo_flag && !drv_dom, "R9 locked", tmo_flag, 1);
    // R3: full recovery
    run(REC, 1'b1, 1'b1, 1'b0, "R3");
    step(1'b0, 1'b1, 1'b0, "R3");
    chk(drv_dom == 1'b1, "R3 rearm dominant", drv_dom, 1);
    // R1: toggle pattern
    for (int i = 0; i < 12; i++) step(i[0] ^ i[2], 1'b1, 1'b0, "R1");
    // R5: short low then high restarts count
    run(TMO - 2, 1'b0, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b0, "R5");
    run(TMO - 1, 1'b0, 1'b1, 1'b0, "R5");
    chk(drv_dom == 1'b1 && !tmo_flag, "R5 still dominant", drv_dom, 1);
    // R2: reach the limit exactly
    step(1'b0, 1'b1, 1'b0, "R2");
    step(1'b0, 1'b1, 1'b0, "R2");
    chk(drv_dom == 1'b0 && tmo_flag, "R2 released", drv_dom, 0);
    // R4: short high pulses do not clear
    run(REC - 1, 1'b1, 1'b1, 1'b0, "R4");
    step(1'b0, 1'b1, 1'b0, "R4");
    chk(tmo_flag == 1'b1, "R4 held", tmo_flag, 1);
    run(REC - 2, 1'b1, 1'b1, 1'b0, "R4");
    run(2, 1'b0, 1'b1, 1'b0, "R4");
    run(REC, 1'b1, 1'b1, 1'b0, "R4");
    step(1'b1, 1'b1, 1'b0, "R4");
    chk(tmo_flag == 1'b0, "R4 cleared", tmo_flag, 0);
    // R7: overtemp gates but timer runs, overlapping the limit cycle
    run(TMO - 3, 1'b0, 1'b1, 1'b0, "R7");
    run(5, 1'b0, 1'b1, 1'b1, "R7");
    chk(tmo_flag == 1'b1, "R7 timer ran", tmo_flag, 1);
    run(REC, 1'b1, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b1, 1'b0, "R7");
    chk(drv_dom == 1'b1, "R7 resumes", drv_dom, 1);
    step(1'b1, 1'b1, 1'b0, "R7");
    // R6: path disable in the limit cycle
    run(TMO - 1, 1'b0, 1'b1, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b1, 1'b0, "R6");
    chk(tmo_flag == 1'b0 && drv_dom, "R6 no timeout", tmo_flag, 0);
    run(TMO + 2, 1'b0, 1'b1, 1'b0, "R6");
    run(REC - 1, 1'b1, 1'b1, 1'b0, "R6");
    step(1'b1, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b1, 1'b0, "R6");
    chk(drv_dom == 1'b1, "R6 cleared by disable", drv_dom, 1);
    run(3, 1'b1, 1'b0, 1'b0, "R6");
    run(4, 1'b0, 1'b0, 1'b0, "R6");
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule